// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the control state of one circular descriptor queue that software and a DMA engine share. It holds the ring base address, the ring depth, two ring pointers and two occupancy thresholds. One pointer belongs to software and is loaded through the register port. The other belongs to the DMA engine and moves forward one slot each time the engine asks to advance and the ring can accept the step. From the pointer pair the block derives the occupancy and four flags: empty, full, low and high.

A parameter selects the role of the hardware side. In consumer mode (`HW_PRODUCER = 0`) software fills the ring by moving the write pointer and the engine drains it by moving the read pointer. In producer mode (`HW_PRODUCER = 1`) the engine fills the ring through the write pointer and software moves the read pointer as it retires entries. Pointers are exchanged as byte offsets of 32-byte descriptors. Base, depth and software-pointer writes only take effect while the matching bit of an enable register is set.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset both pointers are 0, the depth is MAX_DEPTH (1024), the enable register is 0, the low threshold is 0 and the high threshold is all ones (1023). The ring then reports empty and low, and neither full nor high.
- R2: Register offsets are 0x00 base, 0x04 depth, 0x08 write pointer, 0x0C read pointer, 0x10 count (read only), 0x14 low threshold, 0x18 high threshold and 0x1C enable. A base write needs enable bit 2, a depth write needs enable bit 1 and a software-pointer write needs enable bit 0. A write without its bit leaves the register unchanged.
- R3: Pointer registers read and write byte offsets. The index is the offset shifted right by 5, reduced modulo the depth. A pointer reads back as its index shifted left by 5.
- R4: The depth register holds the descriptor count shifted left by 3. A write is accepted only if the count is a power of two between 2 and MAX_DEPTH, and otherwise it is ignored. An accepted depth write clears both pointers, and a DMA advance requested in the same cycle is refused.
- R5: count = (write − read) mod depth. Empty means count == 0 and full means count == depth − 1, so one slot always stays unused.
- R6: Low is asserted when count <= low threshold, and high is asserted when count >= high threshold.
- R7: In consumer mode an advance request moves the read pointer forward by one, modulo the depth, only when the ring is not empty. `dma_adv_ok` shows in the same cycle whether the step is taken.
- R8: In producer mode an advance request moves the write pointer forward by one only when the ring is not full.
- R9: The pointer register owned by the hardware side cannot be written through the register port.
- R10: A software-pointer write and a granted advance in the same cycle both take effect.
- R11: The base address is stored with its low 5 bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| dma_adv | input | 1 | DMA request to step the hardware pointer |
| dma_adv_ok | output | 1 | The step is taken at this clock edge |
| dma_idx | output | 10 | Current hardware-pointer index |
| ring_base | output | 32 | Ring base address |
| ring_count | output | 10 | Descriptors between the pointers |
| ring_empty | output | 1 | Count is zero |
| ring_full | output | 1 | Count is depth − 1 |
| ring_low | output | 1 | Count at or below the low threshold |
| ring_high | output | 1 | Count at or above the high threshold |

## Verification
Two updates can land on the same clock edge: a register-port load of the software pointer and a DMA step of the hardware pointer. The bench drives a write-pointer write and an advance request in one cycle on a full ring. Both pointers must then move and the count must come out at the value that reflects both updates. A depth write in the same cycle as an advance is also provoked. There the bench expects the grant to be withheld and both pointers to read back as zero.

// File: rtl/ring_pkg.sv
package ring_pkg;

  localparam int RING_AW = 8;

  typedef enum logic [RING_AW-1:0] {
    RR_BASE   = 8'h00,
    RR_DEPTH  = 8'h04,
    RR_WRPTR  = 8'h08,
    RR_RDPTR  = 8'h0C,
    RR_COUNT  = 8'h10,
    RR_LOW_TH = 8'h14,
    RR_HI_TH  = 8'h18,
    RR_ENABLE = 8'h1C
  } ring_reg_e;

  localparam int EN_SWPTR_BIT = 0;
  localparam int EN_DEPTH_BIT = 1;
  localparam int EN_BASE_BIT  = 2;
  localparam int EN_W         = 3;

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
  import ring_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int MAX_DEPTH   = 1024,
  parameter int DESC_SHIFT  = 5,
  parameter int DEPTH_SHIFT = 3,
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RING_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  base_addr,
  output logic [IDX_W:0]     depth,
  output logic [IDX_W-1:0]   idx_mask,
  output logic [IDX_W-1:0]   low_th,
  output logic [IDX_W-1:0]   high_th,
  output logic [EN_W-1:0]    enable,
  output logic               sw_ptr_we,
  output logic [IDX_W-1:0]   sw_ptr_idx,
  output logic               depth_clr
);

  localparam ring_reg_e SW_REG = HW_PRODUCER ? RR_RDPTR : RR_WRPTR;

  // A legal ring size is a power of two from 2 up to MAX_DEPTH.
  function automatic logic depth_legal(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] d;
    d = w >> DEPTH_SHIFT;
    return (d >= DATA_W'(2)) && (d <= DATA_W'(MAX_DEPTH)) &&
           ((d & (d - 1'b1)) == '0);
  endfunction

  // Convert a byte offset to a descriptor index.
  function automatic logic [IDX_W-1:0] bytes_to_idx(input logic [DATA_W-1:0] w);
    return w[DESC_SHIFT +: IDX_W];
  endfunction

  logic             hit_base, hit_depth, hit_low, hit_high, hit_en;
  logic [IDX_W:0]   depth_m1;

  assign hit_base  = reg_we && (reg_addr == RR_BASE)   && enable[EN_BASE_BIT];
  assign hit_depth = reg_we && (reg_addr == RR_DEPTH)  && enable[EN_DEPTH_BIT];
  assign hit_low   = reg_we && (reg_addr == RR_LOW_TH);
  assign hit_high  = reg_we && (reg_addr == RR_HI_TH);
  assign hit_en    = reg_we && (reg_addr == RR_ENABLE);

  assign depth_clr  = hit_depth && depth_legal(reg_wdata);
  assign sw_ptr_we  = reg_we && (reg_addr == SW_REG) && enable[EN_SWPTR_BIT];
  assign sw_ptr_idx = bytes_to_idx(reg_wdata) & idx_mask;

  assign depth_m1 = depth - 1'b1;
  assign idx_mask = depth_m1[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      depth     <= (IDX_W+1)'(MAX_DEPTH);
      low_th    <= '0;
      high_th   <= '1;
      enable    <= '0;
    end else begin
      if (hit_base)
        base_addr <= {reg_wdata[DATA_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
      if (depth_clr)
        depth <= reg_wdata[DEPTH_SHIFT +: IDX_W+1];
      if (hit_low)
        low_th <= reg_wdata[IDX_W-1:0];
      if (hit_high)
        high_th <= reg_wdata[IDX_W-1:0];
      if (hit_en)
        enable <= reg_wdata[EN_W-1:0];
    end
  end

endmodule

// File: rtl/ring_ptr_pair.sv
module ring_ptr_pair #(
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [IDX_W-1:0] idx_mask,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             adv,
  input  logic             hw_stall,
  output logic             adv_ok,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx
);

  function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] p,
                                                 input logic [IDX_W-1:0] m);
    return (p + 1'b1) & m;
  endfunction

  assign adv_ok = adv && !hw_stall && !clr;

  logic [IDX_W-1:0] hw_q, sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hw_q <= '0;
    else if (clr)    hw_q <= '0;
    else if (adv_ok) hw_q <= ring_step(hw_q, idx_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= '0;
    else if (clr)   sw_q <= '0;
    else if (sw_we) sw_q <= sw_idx;
  end

  generate
    if (HW_PRODUCER) begin : g_hw_fills
      assign wr_idx = hw_q;
      assign rd_idx = sw_q;
    end else begin : g_hw_drains
      assign wr_idx = sw_q;
      assign rd_idx = hw_q;
    end
  endgenerate

endmodule

// File: rtl/ring_status.sv
module ring_status #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] idx_mask,
  input  logic [IDX_W-1:0] low_th,
  input  logic [IDX_W-1:0] high_th,
  output logic [IDX_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             low,
  output logic             high
);

  function automatic logic [IDX_W-1:0] occupancy(input logic [IDX_W-1:0] w,
                                                 input logic [IDX_W-1:0] r,
                                                 input logic [IDX_W-1:0] m);
    return (w - r) & m;
  endfunction

  assign count = occupancy(wr_idx, rd_idx, idx_mask);
  assign empty = (count == '0);
  assign full  = (count == idx_mask);
  assign low   = (count <= low_th);
  assign high  = (count >= high_th);

endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import ring_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int MAX_DEPTH   = 1024,
  parameter int DESC_BYTES  = 32,
  parameter int DEPTH_SHIFT = 3,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [RING_AW-1:0]           reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic                         dma_adv,
  output logic                         dma_adv_ok,
  output logic [$clog2(MAX_DEPTH)-1:0] dma_idx,
  output logic [DATA_W-1:0]            ring_base,
  output logic [$clog2(MAX_DEPTH)-1:0] ring_count,
  output logic                         ring_empty,
  output logic                         ring_full,
  output logic                         ring_low,
  output logic                         ring_high
);

  localparam int IDX_W      = $clog2(MAX_DEPTH);
  localparam int DESC_SHIFT = $clog2(DESC_BYTES);

  logic [IDX_W:0]   depth;
  logic [IDX_W-1:0] idx_mask, low_th, high_th;
  logic [EN_W-1:0]  enable;
  logic             sw_ptr_we, depth_clr, hw_stall, adv_ok;
  logic [IDX_W-1:0] sw_ptr_idx, wr_idx, rd_idx;

  ring_cfg_regs #(
    .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .DESC_SHIFT(DESC_SHIFT),
    .DEPTH_SHIFT(DEPTH_SHIFT), .IDX_W(IDX_W), .HW_PRODUCER(HW_PRODUCER)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base_addr(ring_base), .depth(depth),
    .idx_mask(idx_mask), .low_th(low_th), .high_th(high_th),
    .enable(enable), .sw_ptr_we(sw_ptr_we), .sw_ptr_idx(sw_ptr_idx),
    .depth_clr(depth_clr)
  );

  generate
    if (HW_PRODUCER) begin : g_stall_full
      assign hw_stall = ring_full;
      assign dma_idx  = wr_idx;
    end else begin : g_stall_empty
      assign hw_stall = ring_empty;
      assign dma_idx  = rd_idx;
    end
  endgenerate

  ring_ptr_pair #(.IDX_W(IDX_W), .HW_PRODUCER(HW_PRODUCER)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(depth_clr), .idx_mask(idx_mask),
    .sw_we(sw_ptr_we), .sw_idx(sw_ptr_idx), .adv(dma_adv),
    .hw_stall(hw_stall), .adv_ok(adv_ok), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  assign dma_adv_ok = adv_ok;

  ring_status #(.IDX_W(IDX_W)) u_stat (
    .wr_idx(wr_idx), .rd_idx(rd_idx), .idx_mask(idx_mask),
    .low_th(low_th), .high_th(high_th), .count(ring_count),
    .empty(ring_empty), .full(ring_full), .low(ring_low), .high(ring_high)
  );

  always_comb begin
    case (reg_addr)
      RR_BASE:   reg_rdata = ring_base;
      RR_DEPTH:  reg_rdata = DATA_W'(depth) << DEPTH_SHIFT;
      RR_WRPTR:  reg_rdata = DATA_W'(wr_idx) << DESC_SHIFT;
      RR_RDPTR:  reg_rdata = DATA_W'(rd_idx) << DESC_SHIFT;
      RR_COUNT:  reg_rdata = DATA_W'(ring_count);
      RR_LOW_TH: reg_rdata = DATA_W'(low_th);
      RR_HI_TH:  reg_rdata = DATA_W'(high_th);
      RR_ENABLE: reg_rdata = DATA_W'(enable);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ring_ptr_mgr_chk.sv
module ring_ptr_mgr_chk #(
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rd_idx,
  input logic [IDX_W-1:0] idx_mask,
  input logic             adv_ok,
  input logic             depth_clr,
  input logic             sw_ptr_we,
  input logic [IDX_W-1:0] sw_ptr_idx,
  input logic             ring_empty,
  input logic             ring_full,
  input logic             ring_low,
  input logic [IDX_W-1:0] ring_count
);

  logic [IDX_W-1:0] hw_idx, sw_idx;
  assign hw_idx = HW_PRODUCER ? wr_idx : rd_idx;
  assign sw_idx = HW_PRODUCER ? rd_idx : wr_idx;

  // R7 / R8: a granted advance moves the hardware pointer one slot
  a_r7_hw_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ok |=> hw_idx == (($past(hw_idx) + 1'b1) & $past(idx_mask)));

  // R7 / R8: without a grant or a clear the hardware pointer holds
  a_r7_hw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_ok && !depth_clr) |=> hw_idx == $past(hw_idx));

  // R8 and R7: no grant on a full (producer) or empty (consumer) ring
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (HW_PRODUCER ? ring_full : ring_empty) |-> !adv_ok);

  // R4: an accepted depth write clears both pointers
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    depth_clr |=> (wr_idx == '0) && (rd_idx == '0));

  // R10: a software-pointer write lands regardless of a same-cycle advance
  a_r10_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ptr_we |=> sw_idx == $past(sw_ptr_idx));

  // R5: empty and full never coincide on a legal depth
  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ring_empty && ring_full));

  // R6: an empty ring is always low
  a_r6_low_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_count == '0) |-> ring_low);

endmodule

bind ring_ptr_mgr ring_ptr_mgr_chk #(.IDX_W(IDX_W), .HW_PRODUCER(HW_PRODUCER)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .rd_idx(rd_idx),
  .idx_mask(idx_mask), .adv_ok(adv_ok), .depth_clr(depth_clr),
  .sw_ptr_we(sw_ptr_we), .sw_ptr_idx(sw_ptr_idx), .ring_empty(ring_empty),
  .ring_full(ring_full), .ring_low(ring_low), .ring_count(ring_count)
);

// File: tb/sim_ring_ptr_mgr.sv
`timescale 1ns/1ps
module sim_ring_ptr_mgr;

  localparam int PERIOD = 20;
  localparam int NV     = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we0 = 1'b0, we1 = 1'b0, adv0 = 1'b0, adv1 = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1, base0, base1;
  logic        ok0, ok1;
  logic [9:0]  idx0, idx1, cnt0, cnt1;
  logic        emp0, emp1, ful0, ful1, low0, low1, hi0, hi1;

  int nchk = 0;
  int nerr = 0;

  always #(PERIOD/2) clk = ~clk;

  ring_ptr_mgr #(.HW_PRODUCER(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we0), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata0), .dma_adv(adv0), .dma_adv_ok(ok0), .dma_idx(idx0),
    .ring_base(base0), .ring_count(cnt0), .ring_empty(emp0), .ring_full(ful0),
    .ring_low(low0), .ring_high(hi0));

  ring_ptr_mgr #(.HW_PRODUCER(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_we(we1), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata1), .dma_adv(adv1), .dma_adv_ok(ok1), .dma_idx(idx1),
    .ring_base(base1), .ring_count(cnt1), .ring_empty(emp1), .ring_full(ful1),
    .ring_low(low1), .ring_high(hi1));

  // op(1: 1=read/compare) addr(8) data(32) req(4)
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 8'h1C, 32'h0,        4'd2},   // R2 enable all off
    {1'b0, 8'h08, 32'h40,       4'd2},
    {1'b1, 8'h08, 32'h0,        4'd2},   // R2 pointer write gated
    {1'b0, 8'h1C, 32'h1,        4'd3},
    {1'b0, 8'h08, 32'h60,       4'd3},
    {1'b1, 8'h08, 32'h60,       4'd3},   // R3 byte offset readback
    {1'b1, 8'h10, 32'h3,        4'd5},   // R5 count
    {1'b0, 8'h1C, 32'h0,        4'd2},
    {1'b0, 8'h00, 32'h12345678, 4'd2},
    {1'b1, 8'h00, 32'h0,        4'd2},   // R2 base write gated
    {1'b0, 8'h1C, 32'h4,        4'd11},
    {1'b0, 8'h00, 32'h1234567F, 4'd11},
    {1'b1, 8'h00, 32'h12345660, 4'd11},  // R11 low bits cleared
    {1'b0, 8'h1C, 32'h2,        4'd4},
    {1'b0, 8'h04, 32'h80,       4'd4},
    {1'b1, 8'h04, 32'h80,       4'd4},   // R4 depth 16
    {1'b1, 8'h08, 32'h0,        4'd4},   // R4 pointers cleared
    {1'b1, 8'h10, 32'h0,        4'd4},
    {1'b0, 8'h04, 32'h60,       4'd4},
    {1'b1, 8'h04, 32'h80,       4'd4},   // R4 non power of two ignored
    {1'b0, 8'h04, 32'h8,        4'd4},
    {1'b1, 8'h04, 32'h80,       4'd4},   // R4 depth 1 ignored
    {1'b0, 8'h1C, 32'h1,        4'd3},
    {1'b0, 8'h08, 32'h280,      4'd3},
    {1'b1, 8'h08, 32'h80,       4'd3},   // R3 index wraps by depth
    {1'b0, 8'h0C, 32'h40,       4'd9},
    {1'b1, 8'h0C, 32'h0,        4'd9},   // R9 hardware pointer not writable
    {1'b0, 8'h14, 32'h2,        4'd6},
    {1'b0, 8'h18, 32'h4,        4'd6},
    {1'b1, 8'h18, 32'h4,        4'd6}    // R6 threshold stored
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit u, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we0 = ~u; we1 = u;
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd(input bit u, input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, u ? rdata1 : rdata0, exp);
  endtask

  task automatic pulse(input bit u, input logic exp_ok, input string tag);
    @(negedge clk);
    adv0 = ~u; adv1 = u;
    #1;
    check(tag, {31'b0, u ? ok1 : ok0}, {31'b0, exp_ok});
    @(negedge clk);
    adv0 = 1'b0; adv1 = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, 8'h04, 32'h2000, "R1 depth");
    rd(0, 8'h18, 32'h3FF,  "R1 high th");
    rd(0, 8'h1C, 32'h0,    "R1 enable");
    rd(0, 8'h0C, 32'h0,    "R1 rdptr");
    check("R1 flags", {28'b0, emp0, ful0, low0, hi0}, 32'b1010);
    rd(1, 8'h08, 32'h0,    "R1 u1 wrptr");

    // table walk on the consumer instance
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44])
        rd(0, VEC[i][43:36], VEC[i][35:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      else
        wr(0, VEC[i][43:36], VEC[i][35:4]);
    end

    // state: depth 16, wr 4, rd 0, low th 2, high th 4
    @(negedge clk); #1;
    check("R6 high at 4", {31'b0, hi0}, 32'd1);
    check("R6 low at 4",  {31'b0, low0}, 32'd0);

    pulse(0, 1'b1, "R7 grant");
    rd(0, 8'h0C, 32'h20, "R7 rd step");
    check("R6 high clear at 3", {31'b0, hi0}, 32'd0);
    pulse(0, 1'b1, "R7 grant");
    pulse(0, 1'b1, "R7 grant");
    rd(0, 8'h10, 32'h1, "R5 count 1");
    check("R6 low at 1", {31'b0, low0}, 32'd1);
    pulse(0, 1'b1, "R7 grant last");
    check("R5 empty", {31'b0, emp0}, 32'd1);
    pulse(0, 1'b0, "R7 refuse empty");
    rd(0, 8'h0C, 32'h80, "R7 rd held");

    // full: wr index 3, rd index 4
    wr(0, 8'h08, 32'h60);
    @(negedge clk); #1;
    check("R5 full", {31'b0, ful0}, 32'd1);
    rd(0, 8'h10, 32'hF, "R5 count full");

    // R10 software write and advance together
    @(negedge clk);
    addr = 8'h08; wdata = 32'hC0; we0 = 1'b1; adv0 = 1'b1;
    #1;
    check("R10 grant", {31'b0, ok0}, 32'd1);
    @(negedge clk);
    we0 = 1'b0; adv0 = 1'b0;
    rd(0, 8'h08, 32'hC0, "R10 wr");
    rd(0, 8'h0C, 32'hA0, "R10 rd");
    rd(0, 8'h10, 32'h1,  "R10 count");

    // R7 wrap of the read pointer
    wr(0, 8'h08, 32'h0);
    for (int k = 0; k < 10; k++) pulse(0, 1'b1, "R7 wrap grant");
    rd(0, 8'h0C, 32'h1E0, "R7 rd at top");
    pulse(0, 1'b1, "R7 wrap grant");
    rd(0, 8'h0C, 32'h0, "R7 rd wrapped");
    check("R5 empty after wrap", {31'b0, emp0}, 32'd1);

    // R4 depth write beats an advance
    wr(0, 8'h08, 32'h40);
    wr(0, 8'h1C, 32'h3);
    @(negedge clk);
    addr = 8'h04; wdata = 32'h40; we0 = 1'b1; adv0 = 1'b1;
    #1;
    check("R4 advance refused", {31'b0, ok0}, 32'd0);
    @(negedge clk);
    we0 = 1'b0; adv0 = 1'b0;
    rd(0, 8'h08, 32'h0,  "R4 wr cleared");
    rd(0, 8'h0C, 32'h0,  "R4 rd cleared");
    rd(0, 8'h04, 32'h40, "R4 depth 8");

    // producer instance
    wr(1, 8'h1C, 32'h2);
    wr(1, 8'h04, 32'h20);
    pulse(1, 1'b1, "R8 grant");
    pulse(1, 1'b1, "R8 grant");
    pulse(1, 1'b1, "R8 grant");
    rd(1, 8'h08, 32'h60, "R8 wr step");
    check("R8 full", {31'b0, ful1}, 32'd1);
    pulse(1, 1'b0, "R8 refuse full");
    rd(1, 8'h08, 32'h60, "R8 wr held");
    wr(1, 8'h1C, 32'h1);
    wr(1, 8'h08, 32'h0);
    rd(1, 8'h08, 32'h60, "R9 producer wr not writable");
    wr(1, 8'h0C, 32'h40);
    rd(1, 8'h0C, 32'h40, "R3 producer rd");
    rd(1, 8'h10, 32'h1,  "R5 producer count");

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule